// File: doc/BRIEF.md
# Bit-Serial Symmetric Distributed-Arithmetic FIR Filter

This block is an eight-tap FIR filter with a linear-phase (mirror-symmetric) coefficient set. It trades speed for area: rather than multiplying, it pre-adds each pair of mirrored taps one bit per clock. Each pair has a single-bit full adder whose carry lives in a flip-flop. The four resulting sum bits address one small table that holds every possible sum of the four distinct coefficients. A shifting accumulator folds the table outputs together, least significant bit first, and produces the exact full-precision filter output.

A caller presents a sample on `sample_i` and raises `start_i` for a clock. The sample enters the delay line, the pair sums are formed serially over W+1 cycles, and the result register updates together with a one-cycle `done_o` pulse. A new start may coincide with the final computation cycle, so a continuous stream gets one result every W+1 clocks. Starts at any other time while a computation is running are dropped.

Top module: `serial_da_fir`

## Requirements
- R1: During and after reset, before any sample has been accepted, `result_o` is 0 and `done_o` is low.
- R2: An accepted sample becomes tap 0 and older taps move up by one. Taps j and 7-j share coefficient h[j], a signed CW-bit field at bits [j*CW +: CW] of `COEFS`. `result_o` is the signed, untruncated sum of tap times coefficient over all eight taps.
- R3: If a sample is accepted at clock edge n, `result_o` takes its new value and `done_o` rises at edge n+W+1.
- R4: Each accepted sample yields exactly one `done_o` pulse, and that pulse is one clock wide.
- R5: A start seen while a computation is running, other than in its last cycle, has no effect on the taps or on any later result.
- R6: A start during the last computation cycle is accepted at the same edge that latches the current result, giving one result every W+1 clocks under continuous starts.
- R7: Bit W of each serial pair sum is the sign bit and carries negative weight. The accumulator subtracts on that cycle, so full-scale negative inputs produce exact results.
- R8: `result_o` holds its value between `done_o` pulses.
- R9: Accepting a sample clears the accumulator and all pre-adder carries, so a result does not depend on the result computed before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample strobe; accepted when idle or in the last compute cycle |
| sample_i | input | W | Signed two's-complement input sample |
| result_o | output | W+CW+3 | Signed full-precision filter output |
| done_o | output | 1 | One-cycle pulse when `result_o` updates |

## Verification
The test begins with a unit impulse followed by zeros, fed as isolated starts. The output should walk through the coefficient set in mirror order, which shows whether each tap position maps to the right coefficient and whether the pair indexing is reversed.

Streams of full-scale positive and full-scale negative samples are then driven with `start_i` held high throughout. These exercise carry propagation into the extra pre-adder bit and the subtracted sign cycle, and they confirm that starts arriving mid-computation are dropped while a start on the latch cycle is taken.

A random stream with random junk on the rejected cycles checks general values. Isolated samples following the extreme streams show whether any residue from a previous result survives into the next one. Every result is also compared against its expected arrival cycle.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int TAPS  = 8;
    localparam int PAIRS = TAPS / 2;
    localparam int ROM_N = 1 << PAIRS;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
    import sdf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic carry_clr_o,
    output logic acc_clr_o,
    output logic step_o,
    output logic sub_o,
    output logic latch_o
);
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W);

    typedef struct packed {
        run_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t c_q, c_d;
    logic  last_d, accept_d;

    always_comb begin
        last_d   = (c_q.st == ST_RUN) && (c_q.cnt == LAST_BIT);
        accept_d = start_i && ((c_q.st == ST_IDLE) || last_d);
        c_d      = c_q;
        if (accept_d) begin
            c_d.st  = ST_RUN;
            c_d.cnt = '0;
        end else if (last_d) begin
            c_d.st  = ST_IDLE;
            c_d.cnt = '0;
        end else if (c_q.st == ST_RUN) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cnt: '0};
        else        c_q <= c_d;
    end

    // Clears travel with the load so nothing of the prior result remains.
    assign load_o      = accept_d;
    assign carry_clr_o = accept_d;
    assign acc_clr_o   = accept_d;
    assign step_o      = (c_q.st == ST_RUN);
    assign sub_o       = last_d;
    assign latch_o     = last_d;
endmodule

// File: rtl/sdf_taps.sv
module sdf_taps
    import sdf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             carry_clr_i,
    input  logic             step_i,
    input  logic [W-1:0]     sample_i,
    output logic [PAIRS-1:0] addr_o,
    output logic [W-1:0]     newest_o
);
    typedef struct packed {
        logic [TAPS-1:0][W-1:0]  tap;
        logic [PAIRS-1:0][W-1:0] lo;
        logic [PAIRS-1:0][W-1:0] hi;
        logic [PAIRS-1:0]        cy;
    } line_t;

    line_t l_q, l_d;

    // Serial sum bit of each mirrored pair addresses the shared table.
    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign addr_o[j] = l_q.lo[j][0] ^ l_q.hi[j][0] ^ l_q.cy[j];
    end

    always_comb begin
        l_d = l_q;
        if (step_i) begin
            for (int j = 0; j < PAIRS; j++) begin
                l_d.cy[j] = (l_q.lo[j][0] & l_q.hi[j][0]) |
                            (l_q.cy[j] & (l_q.lo[j][0] ^ l_q.hi[j][0]));
                // Arithmetic shift: after W steps the sign bit feeds bit W.
                l_d.lo[j] = {l_q.lo[j][W-1], l_q.lo[j][W-1:1]};
                l_d.hi[j] = {l_q.hi[j][W-1], l_q.hi[j][W-1:1]};
            end
        end
        if (carry_clr_i) l_d.cy = '0;
        if (load_i) begin
            l_d.tap[0] = sample_i;
            for (int i = 1; i < TAPS; i++) l_d.tap[i] = l_q.tap[i-1];
            for (int j = 0; j < PAIRS; j++) begin
                l_d.lo[j] = l_d.tap[j];
                l_d.hi[j] = l_d.tap[TAPS-1-j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign newest_o = l_q.tap[0];
endmodule

// File: rtl/sdf_rom.sv
module sdf_rom
    import sdf_pkg::*;
#(
    parameter int                  CW    = 8,
    parameter logic [PAIRS*CW-1:0] COEFS = 32'h3C14FB03,
    parameter int                  TW    = CW + 2
) (
    input  logic [PAIRS-1:0] addr_i,
    output logic [TW-1:0]    p_o
);
    function automatic logic [TW-1:0] entry(int e);
        logic [TW-1:0] acc;
        logic [CW-1:0] c;
        acc = '0;
        for (int j = 0; j < PAIRS; j++) begin
            c = COEFS[j*CW +: CW];
            if (e[j]) acc = acc + {{(TW-CW){c[CW-1]}}, c};
        end
        return acc;
    endfunction

    logic [TW-1:0] rom [ROM_N];

    for (genvar e = 0; e < ROM_N; e++) begin : g_ent
        assign rom[e] = entry(e);
    end

    assign p_o = rom[addr_i];
endmodule

// File: rtl/sdf_acc.sv
module sdf_acc #(
    parameter int W  = 8,
    parameter int TW = 10,
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    input  logic          sub_i,
    input  logic [TW-1:0] p_i,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] next_o
);
    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_t;

    acc_t          a_q, a_d;
    logic [AW-1:0] term_d, half_d, step_d;

    always_comb begin
        term_d = AW'({{(AW-TW){p_i[TW-1]}}, p_i}) << W;
        half_d = AW'($signed(a_q.acc) >>> 1);
        step_d = sub_i ? (half_d - term_d) : (half_d + term_d);
        a_d    = a_q;
        if (clr_i)       a_d.acc = '0;
        else if (step_i) a_d.acc = step_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign acc_o  = a_q.acc;
    assign next_o = step_d;
endmodule

// File: rtl/serial_da_fir.sv
module serial_da_fir
    import sdf_pkg::*;
#(
    parameter int                  W     = 8,
    parameter int                  CW    = 8,
    parameter logic [PAIRS*CW-1:0] COEFS = 32'h3C14FB03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [W-1:0]    sample_i,
    output logic [W+CW+2:0] result_o,
    output logic            done_o
);
    localparam int RW = W + CW + 3;
    localparam int TW = CW + 2;

    logic             load_w, carry_clr_w, acc_clr_w, step_w, sub_w, latch_w;
    logic [PAIRS-1:0] addr_w;
    logic [W-1:0]     newest_w;
    logic [TW-1:0]    p_w;
    logic [RW-1:0]    acc_w, next_w;

    sdf_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load_w), .carry_clr_o(carry_clr_w), .acc_clr_o(acc_clr_w),
        .step_o(step_w), .sub_o(sub_w), .latch_o(latch_w)
    );

    sdf_taps #(.W(W)) u_taps (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .carry_clr_i(carry_clr_w),
        .step_i(step_w), .sample_i(sample_i), .addr_o(addr_w), .newest_o(newest_w)
    );

    sdf_rom #(.CW(CW), .COEFS(COEFS), .TW(TW)) u_rom (
        .addr_i(addr_w), .p_o(p_w)
    );

    sdf_acc #(.W(W), .TW(TW), .AW(RW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(acc_clr_w), .step_i(step_w),
        .sub_i(sub_w), .p_i(p_w), .acc_o(acc_w), .next_o(next_w)
    );

    typedef struct packed {
        logic [RW-1:0] res;
        logic          done;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d      = o_q;
        o_d.done = latch_w;
        if (latch_w) o_d.res = next_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign result_o = o_q.res;
    assign done_o   = o_q.done;
endmodule

// File: rtl/sdf_chk.sv
module sdf_chk #(
    parameter int W  = 8,
    parameter int RW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [RW-1:0] result_o,
    input logic          load_i,
    input logic          latch_i,
    input logic          sub_i,
    input logic [RW-1:0] acc_i,
    input logic [W-1:0]  newest_i
);
    localparam int GW = $clog2(W + 3);
    localparam logic [GW-1:0] GMAX = GW'(W + 2);
    localparam logic [GW-1:0] GLAT = GW'(W + 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           gap_q <= '0;
        else if (load_i)                      gap_q <= GW'(1);
        else if (gap_q != '0 && gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |-> (gap_q == GLAT));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !load_i) |=> $stable(newest_i));

    assert_sign_subtract_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sub_i));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_i == '0));
endmodule

bind serial_da_fir sdf_chk #(.W(W), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .result_o(result_o), .load_i(load_w), .latch_i(latch_w), .sub_i(sub_w),
    .acc_i(acc_w), .newest_i(newest_w)
);

// File: tb/serial_da_fir_test.sv
`timescale 1ns/1ps
module serial_da_fir_test;
    localparam int W   = 8;
    localparam int CW  = 8;
    localparam int RW  = W + CW + 3;
    localparam int LAT = W + 2;
    localparam int H [4] = '{3, -5, 20, 60};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  sample_i = '0;
    logic [RW-1:0] result_o;
    logic          done_o;

    serial_da_fir #(.W(W), .CW(CW), .COEFS(32'h3C14FB03)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
        .result_o(result_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int     n_chk = 0, n_fail = 0;
    int     hist [8];
    int     q_val [$];
    longint q_due [$];
    string  q_tag [$];
    int     hold_err = 0, double_err = 0;
    logic   prev_done = 1'b0;
    logic [RW-1:0] held = '0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Scoreboard push: model the delay line and expected arrival cycle.
    task automatic push(int s, string tag);
        int e;
        for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        e = 0;
        for (int i = 0; i < 8; i++) e += H[(i < 4) ? i : 7 - i] * hist[i];
        q_val.push_back(e);
        q_due.push_back(cyc + LAT);
        q_tag.push_back(tag);
    endtask

    task automatic send_one(int s, string tag);
        @(negedge clk);
        start_i = 1'b1; sample_i = W'(s); push(s, tag);
        @(negedge clk);
        start_i = 1'b0;
        repeat (W + 2) @(negedge clk);
    endtask

    // Start held high: W junk cycles (dropped), then the next real sample on the latch cycle.
    task automatic send_stream(int n, int mode, string tag);
        int s;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s = (mode == 0) ? 127 : (mode == 1) ? -128 : (int'($urandom % 256) - 128);
            start_i = 1'b1; sample_i = W'(s); push(s, tag);
            for (int g = 0; g < W; g++) begin
                @(negedge clk);
                sample_i = W'($urandom);
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (W + 4) @(negedge clk);
    endtask

    task automatic send_poked(int s, int junk);
        @(negedge clk);
        start_i = 1'b1; sample_i = W'(s); push(s, "R5");
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; sample_i = W'(junk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (W + 2) @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        int     e;
        longint due;
        string  tag;
        if (rst_n) begin
            if (done_o && prev_done) double_err++;
            if (!done_o && result_o != held) hold_err++;
            if (done_o) begin
                held = result_o;
                if (q_val.size() == 0) begin
                    check(1'b0, "R5", "unexpected result", longint'($signed(result_o)), 0);
                end else begin
                    e = q_val.pop_front(); due = q_due.pop_front(); tag = q_tag.pop_front();
                    check(longint'($signed(result_o)) == e, tag, "result value",
                          longint'($signed(result_o)), e);
                    check(cyc == due, "R3", "result cycle", cyc, due);
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check(result_o == '0, "R1", "result in reset", longint'(result_o), 0);
        check(done_o == 1'b0, "R1", "done in reset", longint'(done_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(result_o == '0, "R1", "result after reset", longint'(result_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", longint'(done_o), 0);

        // R2: impulse walks through the mirrored coefficients
        send_one(1, "R2");
        for (int k = 0; k < 8; k++) send_one(0, "R2");

        // R6: continuous starts, full-scale positive
        send_stream(9, 0, "R6");
        // R7: full-scale negative, sign cycle subtracts
        send_stream(9, 1, "R7");
        // R9: isolated results after extremes carry no residue
        send_one(37, "R9");
        send_one(-3, "R9");
        // R5: dropped starts with random junk
        send_stream(12, 2, "R5");
        send_poked(-77, 101);
        send_poked(55, -128);

        repeat (LAT + 4) @(negedge clk);
        check(q_val.size() == 0, "R4", "missing results", q_val.size(), 0);
        check(double_err == 0, "R4", "done wider than one cycle", double_err, 0);
        check(hold_err == 0, "R8", "result changed without done", hold_err, 0);
        summary();
        $finish;
    end
endmodule